// File: doc/BRIEF.md
# Dithered 7-bit Pulse-Width Modulator

This block produces a pulse-width modulated level from a 7-bit up counter. The counter advances one step on every clock in which the source-clock enable is high, so each period is 128 enabled ticks long. A period opens at a chosen initial level. When the counter reaches the compare point, the level flips, and at the wrap back to zero it returns to the initial level. A one-clock interrupt request marks every wrap.

A dither option shifts the compare point one count later on every second period of a run. Over a pair of periods the initial-level phase then averages half a count longer, which gives close to 8-bit resolution from a 7-bit duty value. The output may also be gated, through a logical AND, with a pulse from a companion timer, for example to chop a carrier into bursts.

The control is a three-state machine. `ST_IDLE` means stopped. `ST_LEAD` is the initial-level phase of a period and `ST_TRAIL` is the flipped phase. These transitions are named:
- *start*: `ST_IDLE` to `ST_LEAD` when run is seen high.
- *match*: `ST_LEAD` to `ST_TRAIL` on a compare hit.
- *wrap*: `ST_LEAD` or `ST_TRAIL` to `ST_LEAD` when the counter passes 127.
- *halt*: any running state to `ST_IDLE` when run is low.

Top module: `dpwm_gen`

## Requirements
- R1: While stopped (state `ST_IDLE`, including during and after reset), the level is `idle_level`. The pin shows that level, ANDed with `peer_pulse` when `and_en` is 1.
- R2: On the clock edge where `run` is first seen high, the counter is set to 0. After that it advances by one on each clock with `tick_en` high. When `run` is seen low, the block returns to `ST_IDLE` with the counter at 0.
- R3: The level of a period is the initial level (`idle_level` latched at start) while the counter is at or below the compare point. On the enabled tick at which the counter equals the compare point, the level flips to the inverse of the initial level. With `tick_en` held high, this gives compare+1 clocks at the initial level.
- R4: A period lasts 128 enabled ticks. On the tick at counter value 127, the counter wraps to 0 and the level returns to the initial level.
- R5: With dither latched at 1, the 2nd, 4th, 6th and later periods of a run use compare point duty+1. Their initial phase is then duty+2 ticks, while the odd periods keep duty+1 ticks.
- R6: With dither latched at 0, every period uses compare point duty, so every initial phase is duty+1 ticks.
- R7: With `and_en` at 1, `pwm_out` is the AND of the internal level and `peer_pulse`. With `and_en` at 0, `pwm_out` is the internal level.
- R8: `period_irq` is high for exactly the one clock that follows each wrap tick, which is the first clock of the new period, and is low otherwise.
- R9: The odd/even period tracker restarts at start, so the first period of every run is odd (no stretch) and the second is the first stretched one.
- R10: `duty` and `dither_en` are sampled only at start and at each wrap. A change in the middle of a period first takes effect in the following period.
- R11: When the compare point is 127 or 128 (duty 127, with or without the stretch), no flip happens in that period: the wrap takes priority and the level stays at the initial level for all 128 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Source-clock enable; the counter steps on clocks where it is high |
| run | input | 1 | 1 = run, 0 = stop |
| duty | input | 7 | Compare value for the level flip |
| dither_en | input | 1 | 1 = stretch every second period by one count |
| idle_level | input | 1 | Initial level of each period and the stopped level |
| and_en | input | 1 | 1 = AND the output with `peer_pulse` |
| peer_pulse | input | 1 | Output of the companion timer |
| pwm_out | output | 1 | Modulated output level |
| period_irq | output | 1 | One-clock pulse at the start of each new period |

## Verification
The assertions take for granted that `run` and `tick_en` are ordinary synchronous levels and that `duty` may change at any clock. They rely on the block's own sampling to keep a mid-period change from showing. The stimulus drives every input a short time after the rising edge. It runs directed phases with `tick_en` held high, so that phase lengths can be counted in clocks, and a long random phase in which `tick_en`, `duty`, `dither_en`, `peer_pulse` and `run` all move. A behavioural model follows the pin and the interrupt on every clock throughout.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } pwm_state_e;
endpackage

// File: rtl/dpwm_counter.sv
module dpwm_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             even_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             even_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            even_q <= 1'b0;
        end else if (clear_i) begin
            cnt_q  <= '0;
            even_q <= 1'b0;
        end else if (adv_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_TOP) begin
                even_q <= ~even_q;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign even_o = even_q;
    assign wrap_o = adv_i && !clear_i && (cnt_q == CNT_TOP);

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clear_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clear_i) |=> $stable(cnt_q)); // R2
    AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (even_q != $past(even_q))); // R5
endmodule

// File: rtl/dpwm_compare.sv
module dpwm_compare #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_first_i,
    input  logic             load_wrap_i,
    input  logic             even_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             dither_i,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             match_o
);
    localparam int CMP_W = CNT_W + 1;
    localparam logic [CMP_W-1:0] PERIOD = CMP_W'(1) << CNT_W;

    logic [CMP_W-1:0] cmp_q;
    logic             stretch_next;

    // even_i is the parity of the period now ending; the next one is even when this is odd
    assign stretch_next = dither_i && !even_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (load_first_i) begin
            cmp_q <= {1'b0, duty_i};
        end else if (load_wrap_i) begin
            cmp_q <= {1'b0, duty_i} + CMP_W'(stretch_next);
        end
    end

    assign match_o = adv_i && ({1'b0, cnt_i} == cmp_q);

    AST_CMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_q <= PERIOD); // R11
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_first_i && !load_wrap_i) |=> $stable(cmp_q)); // R10
    AST_FIRST_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        load_first_i |=> (cmp_q[CNT_W] == 1'b0)); // R9
endmodule

// File: rtl/dpwm_fsm.sv
module dpwm_fsm
    import dpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic match_i,
    input  logic wrap_i,
    input  logic idle_level_i,
    output logic start_o,
    output logic running_o,
    output logic level_o,
    output logic irq_o
);
    pwm_state_e state_q, state_d;
    logic       init_q;
    logic       irq_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_i) state_d = ST_LEAD;               // start
            end
            ST_LEAD: begin
                if (!run_i)       state_d = ST_IDLE;        // halt
                else if (wrap_i)  state_d = ST_LEAD;        // wrap
                else if (match_i) state_d = ST_TRAIL;       // match
            end
            ST_TRAIL: begin
                if (!run_i)      state_d = ST_IDLE;         // halt
                else if (wrap_i) state_d = ST_LEAD;         // wrap
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (start_o) init_q <= idle_level_i;
            irq_q <= wrap_i;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_LEAD:  level_o = init_q;
            ST_TRAIL: level_o = ~init_q;
            default:  level_o = idle_level_i;
        endcase
    end

    assign start_o   = (state_q == ST_IDLE) && run_i;
    assign running_o = (state_q != ST_IDLE);
    assign irq_o     = irq_q;

    AST_LEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD && !match_i) |=> (state_q != ST_TRAIL)); // R3
    AST_WRAP_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> (state_q == ST_LEAD)); // R4
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R8
    AST_START_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (state_q == ST_LEAD)); // R2
    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state_q == ST_IDLE)); // R2
endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run,
    input  logic [CNT_W-1:0] duty,
    input  logic             dither_en,
    input  logic             idle_level,
    input  logic             and_en,
    input  logic             peer_pulse,
    output logic             pwm_out,
    output logic             period_irq
);
    logic [CNT_W-1:0] cnt;
    logic             wrap, even, match;
    logic             start, running, level;
    logic             adv, clear;

    assign adv   = running && run && tick_en;
    assign clear = !(running && run);

    dpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .adv_i   (adv),
        .cnt_o   (cnt),
        .wrap_o  (wrap),
        .even_o  (even)
    );

    dpwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_first_i (start),
        .load_wrap_i  (wrap),
        .even_i       (even),
        .duty_i       (duty),
        .dither_i     (dither_en),
        .adv_i        (adv),
        .cnt_i        (cnt),
        .match_o      (match)
    );

    dpwm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .match_i      (match),
        .wrap_i       (wrap),
        .idle_level_i (idle_level),
        .start_o      (start),
        .running_o    (running),
        .level_o      (level),
        .irq_o        (period_irq)
    );

    assign pwm_out = and_en ? (level & peer_pulse) : level;

    AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pwm_out == (and_en ? (idle_level & peer_pulse) : idle_level))); // R1
    AST_AND_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (and_en && !peer_pulse) |-> !pwm_out); // R7
endmodule

// File: tb/dpwm_gen_tb.sv
module dpwm_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n, tick_en, run, dither_en, idle_level, and_en, peer_pulse;
    logic [6:0] duty;
    logic       pwm_out, period_irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R2";
    bit    cmp_on = 0;

    // behavioural model state
    bit m_run, m_tog, m_even, m_init, m_irq;
    int m_cnt, m_cmp;

    always #10 clk = ~clk;

    dpwm_gen u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .duty(duty),
        .dither_en(dither_en), .idle_level(idle_level), .and_en(and_en),
        .peer_pulse(peer_pulse), .pwm_out(pwm_out), .period_irq(period_irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_tog = 0; m_even = 0; m_init = 0; m_irq = 0; m_cnt = 0; m_cmp = 0;
        end else begin
            m_irq = 0;
            if (!m_run) begin
                if (run) begin
                    m_run = 1; m_cnt = 0; m_tog = 0; m_even = 0;
                    m_cmp = duty; m_init = idle_level;
                end
            end else if (!run) begin
                m_run = 0; m_cnt = 0; m_tog = 0;
            end else if (tick_en) begin
                if (m_cnt == 127) begin
                    m_cnt = 0; m_tog = 0; m_even = !m_even; m_irq = 1;
                    m_cmp = duty + ((dither_en && m_even) ? 1 : 0);
                end else begin
                    if (m_cnt == m_cmp) m_tog = 1;
                    m_cnt++;
                end
            end
        end
    end

    function automatic bit model_pin();
        bit lv;
        lv = m_run ? (m_init ^ m_tog) : idle_level;
        return and_en ? (lv & peer_pulse) : lv;
    endfunction

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            n_cmp++;
            if (pwm_out !== model_pin() || period_irq !== m_irq) begin
                n_bad++;
                $display("FAIL %s t=%0t pin/irq actual=%b/%b expected=%b/%b",
                         cur_req, $time, pwm_out, period_irq, model_pin(), m_irq);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // count clocks at the initial level over one 128-clock period (tick_en held high)
    task automatic window(input int exp_lead, input bit lvl, input string tag,
                          input int chg_at, input logic [6:0] chg_duty);
        int lead = 0;
        int early = 0;
        @(negedge clk);
        while (!period_irq) @(negedge clk);
        for (int i = 0; i < 128; i++) begin
            if (i > 0) @(negedge clk);
            if (pwm_out == lvl) lead++;
            if (i > 0 && period_irq) early++;
            if (i == chg_at) duty = chg_duty;
        end
        chk(lead == exp_lead, tag, lead, exp_lead);
        chk(early == 0, "R4 no irq inside period", early, 0);
    endtask

    initial begin
        rst_n = 0; tick_en = 0; run = 0; duty = 0; dither_en = 0;
        idle_level = 0; and_en = 0; peer_pulse = 0;
        step(3);
        chk(pwm_out == 0, "R1 reset level low", pwm_out, 0);
        chk(period_irq == 0, "R8 reset irq low", period_irq, 0);
        idle_level = 1; step(1);
        chk(pwm_out == 1, "R1 stopped level high", pwm_out, 1);
        idle_level = 0;
        rst_n = 1; step(2);
        cmp_on = 1;
        chk(pwm_out == 0, "R1 stopped after reset", pwm_out, 0);

        // plain PWM, dither off
        cur_req = "R6"; duty = 40; tick_en = 1; run = 1;
        window(41, 0, "R6 period2 lead", -1, 0);
        window(41, 0, "R6 period3 lead", -1, 0);
        window(41, 0, "R3 period4 lead", -1, 0);

        // dither on, parity from start
        cur_req = "R5"; run = 0; step(2);
        dither_en = 1; run = 1;
        window(42, 0, "R5 even period stretched", -1, 0);
        window(41, 0, "R5 odd period plain", -1, 0);
        window(42, 0, "R5 next even stretched", -1, 0);
        cur_req = "R9"; step(1); run = 0; step(2); run = 1;
        window(42, 0, "R9 parity restarts at start", -1, 0);

        // inverted initial level
        cur_req = "R3"; run = 0; dither_en = 0; idle_level = 1; duty = 10; step(2);
        chk(pwm_out == 1, "R1 stopped follows idle_level", pwm_out, 1);
        run = 1;
        window(11, 1, "R3 high initial phase", -1, 0);

        // compare point at the top of the range
        cur_req = "R11"; run = 0; idle_level = 0; duty = 127; dither_en = 1; step(2); run = 1;
        window(128, 0, "R11 compare 128 no flip", -1, 0);
        window(128, 0, "R11 compare 127 no flip", -1, 0);

        // mid-period duty change
        cur_req = "R10"; run = 0; dither_en = 0; duty = 40; step(2); run = 1;
        window(41, 0, "R10 old duty kept in period", 20, 7'd90);
        window(91, 0, "R10 new duty next period", -1, 0);

        // AND combine
        cur_req = "R7"; run = 0; idle_level = 1; and_en = 1; peer_pulse = 0; step(2);
        chk(pwm_out == 0, "R7 peer low masks", pwm_out, 0);
        peer_pulse = 1; step(1);
        chk(pwm_out == 1, "R7 peer high passes", pwm_out, 1);
        run = 1; duty = 30;
        for (int i = 0; i < 600; i++) begin
            peer_pulse = $urandom_range(0, 1);
            step(1);
        end
        and_en = 0;

        // random traffic
        cur_req = "R2";
        for (int i = 0; i < 6000; i++) begin
            tick_en = $urandom_range(0, 3) != 0;
            if ($urandom_range(0, 199) == 0) duty = 7'($urandom_range(0, 127));
            if ($urandom_range(0, 399) == 0) dither_en = ~dither_en;
            if ($urandom_range(0, 999) == 0) run = ~run;
            if ($urandom_range(0, 499) == 0) idle_level = ~idle_level;
            if ($urandom_range(0, 299) == 0) and_en = ~and_en;
            peer_pulse = $urandom_range(0, 1);
            step(1);
        end
        run = 0; step(2);
        cmp_on = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule